// File: doc/BRIEF.md
# Signal Envelope Min/Max Tracker

This block watches a stream of unsigned magnitude samples and keeps the smallest and the largest value seen since the last re-seed. It reports both extremes and the spread between them. When the spread is larger than a programmable limit, it sets a sticky mismatch flag. The flag warns of an envelope that is distorted or unbalanced.

The extremes are never forced to full-scale limits. A fault-clear pulse loads them from two 7-bit seed registers. The minimum is taken from a seed that normally sits high and the maximum from a seed that normally sits low, so the first real samples replace both extremes. The seeds are written and read through a small register port: select 0 is the minimum seed and select 1 is the maximum seed.

A two-state machine controls the tracking. In SEEDED, the extremes hold seed values and no sample has arrived since the reload. In TRACK, at least one sample has been folded in. The transition SEEDED->TRACK (`first_sample`) happens on a valid sample without a clear. The transition any->SEEDED (`reload`) happens on a fault clear. TRACK->TRACK (`fold`) happens on each further sample.

Top module: `env_tracker`

## Requirements
- R1: After reset, the minimum seed reads back 0x68 (select 0) and the maximum seed reads back 0x3C (select 1). `env_min` is 104, `env_max` is 60, `env_spread` is 0, `mis_flag` is 0, and the state is SEEDED.
- R2: A write with `cfg_wr` high stores `cfg_wdata[6:0]` in the seed chosen by `cfg_sel` (0 = minimum seed, 1 = maximum seed). Bit 7 is stored as 0, so `cfg_rdata[7]` always reads 0. A seed write does not change the current extremes.
- R3: On a valid sample with no clear, `env_min` becomes the sample when the sample is smaller, and is otherwise unchanged. The new value is visible after that clock edge.
- R4: On a valid sample with no clear, `env_max` becomes the sample when the sample is larger, and is otherwise unchanged. The new value is visible after that clock edge.
- R5: In TRACK, `env_spread` equals `env_max - env_min`. In SEEDED, `env_spread` is 0.
- R6: In TRACK, if `env_spread` is strictly greater than `mis_lim` in a cycle, `mis_flag` is 1 after the next edge. A spread equal to the limit does not set the flag.
- R7: Once set, `mis_flag` stays 1 until a fault clear, even if the spread later drops to or below the limit.
- R8: `flt_clr` loads `env_min` from the minimum seed and `env_max` from the maximum seed. It also clears `mis_flag` and enters SEEDED, all at the same edge.
- R9: When `flt_clr` and `smp_vld` are both high in the same cycle, the reload wins and that sample has no effect on the extremes.
- R10: In SEEDED, `mis_flag` is never set, even with `mis_lim` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe |
| smp_mag | input | 7 | Unsigned sample magnitude |
| cfg_wr | input | 1 | Seed register write enable |
| cfg_sel | input | 1 | Seed select: 0 minimum seed, 1 maximum seed |
| cfg_wdata | input | 8 | Seed write data |
| cfg_rdata | output | 8 | Seed readback for the selected seed |
| mis_lim | input | 7 | Mismatch spread limit |
| flt_clr | input | 1 | Fault clear and reload pulse |
| env_min | output | 7 | Current minimum |
| env_max | output | 7 | Current maximum |
| env_spread | output | 7 | Max minus min (0 in SEEDED) |
| mis_flag | output | 1 | Sticky mismatch flag |

## Verification
A corrupted extreme shows up on `env_min` or `env_max` right after the edge that wrote it. It also appears on `env_spread` in the same cycle, so every step of the bench compares all three against a model. A wrong state is most visible through the spread and the flag. A stuck SEEDED state reports a zero spread after a sample. A stuck TRACK state reports a wrapped spread after a reload and can raise the flag one edge later. For this reason the bench samples the flag one edge after each spread change, with limits on both sides of the equality boundary.

// File: rtl/env_pkg.sv
package env_pkg;
    localparam int unsigned MAG_W = 7;

    typedef enum logic [0:0] {
        ST_SEEDED = 1'b0,
        ST_TRACK  = 1'b1
    } env_state_e;
endpackage

// File: rtl/env_seed_regs.sv
module env_seed_regs #(
    parameter int unsigned             SEED_W  = 7,
    parameter logic [SEED_W-1:0]       DEF_MIN = 7'h68,
    parameter logic [SEED_W-1:0]       DEF_MAX = 7'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [SEED_W:0]   cfg_wdata,
    output logic [SEED_W:0]   cfg_rdata,
    output logic [SEED_W-1:0] seed_min,
    output logic [SEED_W-1:0] seed_max
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_min <= DEF_MIN;
            seed_max <= DEF_MAX;
        end else if (cfg_wr) begin
            // top bit of the write data is dropped (R2)
            if (cfg_sel) seed_max <= cfg_wdata[SEED_W-1:0];
            else         seed_min <= cfg_wdata[SEED_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = {1'b0, (cfg_sel ? seed_max : seed_min)};
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> (seed_min == $past(cfg_wdata[SEED_W-1:0])));
endmodule

// File: rtl/env_extremes.sv
module env_extremes
    import env_pkg::*;
#(
    parameter int unsigned       W       = 7,
    parameter logic [W-1:0]      DEF_MIN = 7'h68,
    parameter logic [W-1:0]      DEF_MAX = 7'h3C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_mag,
    input  logic         flt_clr,
    input  logic [W-1:0] seed_min,
    input  logic [W-1:0] seed_max,
    output logic [W-1:0] min_q,
    output logic [W-1:0] max_q,
    output logic [W-1:0] spread,
    output logic         tracking
);
    env_state_e state_q, state_d;
    logic       take;

    always_comb take = smp_vld && !flt_clr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEEDED;
        else        state_q <= state_d;
    end

    // transitions: reload, first_sample, fold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEDED: if (flt_clr) state_d = ST_SEEDED;
                       else if (smp_vld) state_d = ST_TRACK;
            ST_TRACK:  if (flt_clr) state_d = ST_SEEDED;
            default:   state_d = ST_SEEDED;
        endcase
    end

    // extremes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_q <= DEF_MIN;
            max_q <= DEF_MAX;
        end else if (flt_clr) begin
            min_q <= seed_min;
            max_q <= seed_max;
        end else if (take) begin
            if (smp_mag < min_q) min_q <= smp_mag;
            if (smp_mag > max_q) max_q <= smp_mag;
        end
    end

    // outputs
    always_comb begin
        tracking = 1'b0;
        spread   = '0;
        unique case (state_q)
            ST_SEEDED: spread = '0;
            ST_TRACK: begin
                tracking = 1'b1;
                spread   = max_q - min_q;
            end
            default: spread = '0;
        endcase
    end

    assert_reload_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> (min_q == $past(seed_min) && max_q == $past(seed_max) && !tracking));
    assert_collide_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr && smp_vld) |=> !tracking);
    assert_min_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (min_q <= $past(smp_mag)));
    assert_max_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (max_q >= $past(smp_mag)));
    assert_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tracking |-> (max_q >= min_q));
endmodule

// File: rtl/env_mismatch.sv
module env_mismatch #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tracking,
    input  logic [W-1:0] spread,
    input  logic [W-1:0] lim,
    input  logic         flt_clr,
    output logic         flag_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag_q <= 1'b0;
        else if (flt_clr)                    flag_q <= 1'b0;
        else if (tracking && (spread > lim)) flag_q <= 1'b1;
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flt_clr) |=> flag_q);
    assert_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tracking && (spread > lim)));
    assert_seeded_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tracking && !flag_q) |=> !flag_q);
endmodule

// File: rtl/env_tracker.sv
module env_tracker
    import env_pkg::*;
#(
    parameter int unsigned    W       = MAG_W,
    parameter logic [W-1:0]   DEF_MIN = 7'h68,
    parameter logic [W-1:0]   DEF_MAX = 7'h3C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic [W-1:0] smp_mag,
    input  logic         cfg_wr,
    input  logic         cfg_sel,
    input  logic [W:0]   cfg_wdata,
    output logic [W:0]   cfg_rdata,
    input  logic [W-1:0] mis_lim,
    input  logic         flt_clr,
    output logic [W-1:0] env_min,
    output logic [W-1:0] env_max,
    output logic [W-1:0] env_spread,
    output logic         mis_flag
);
    logic [W-1:0] seed_min, seed_max;
    logic         tracking;

    env_seed_regs #(.SEED_W(W), .DEF_MIN(DEF_MIN), .DEF_MAX(DEF_MAX)) u_seeds (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .seed_min(seed_min), .seed_max(seed_max)
    );

    env_extremes #(.W(W), .DEF_MIN(DEF_MIN), .DEF_MAX(DEF_MAX)) u_ext (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .flt_clr(flt_clr), .seed_min(seed_min), .seed_max(seed_max),
        .min_q(env_min), .max_q(env_max), .spread(env_spread), .tracking(tracking)
    );

    env_mismatch #(.W(W)) u_mis (
        .clk(clk), .rst_n(rst_n), .tracking(tracking), .spread(env_spread),
        .lim(mis_lim), .flt_clr(flt_clr), .flag_q(mis_flag)
    );
endmodule

// File: tb/test_env_tracker.sv
module test_env_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0, flt_clr = 1'b0;
    logic [6:0] smp_mag = '0, mis_lim = 7'd127;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [6:0] env_min, env_max, env_spread;
    logic       mis_flag;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    // reference model
    int m_min = 104, m_max = 60, s_min = 104, s_max = 60;
    bit m_trk = 0, m_flag = 0;

    always #2.5 clk = ~clk;

    env_tracker i_env_tracker (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mis_lim(mis_lim), .flt_clr(flt_clr), .env_min(env_min), .env_max(env_max),
        .env_spread(env_spread), .mis_flag(mis_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_spread();
        return m_trk ? (m_max - m_min) : 0;
    endfunction

    // one clock: drive at negedge, update model, check after posedge
    task automatic step(input bit vld, input int mag, input bit clr, input int lim);
        @(negedge clk);
        smp_vld = vld; smp_mag = mag[6:0]; flt_clr = clr; mis_lim = lim[6:0];
        if (clr) m_flag = 0;
        else if (m_trk && m_spread() > lim) m_flag = 1;
        if (clr) begin m_min = s_min; m_max = s_max; m_trk = 0; end
        else if (vld) begin
            if (mag < m_min) m_min = mag;
            if (mag > m_max) m_max = mag;
            m_trk = 1;
        end
        @(posedge clk); #1;
        smp_vld = 0; flt_clr = 0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " min"}, env_min, m_min);
        chk({tag, " max"}, env_max, m_max);
        chk({tag, " spread"}, env_spread, m_spread());
        chk({tag, " flag"}, mis_flag, m_flag);
    endtask

    task automatic write_seed(input bit sel, input int data);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = data[7:0];
        if (sel) s_max = data & 8'h7F; else s_min = data & 8'h7F;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic t_reset();
        check_all("R1 reset");
        cfg_sel = 0; #1; chk("R1 seed min readback", cfg_rdata, 8'h68);
        cfg_sel = 1; #1; chk("R1 seed max readback", cfg_rdata, 8'h3C);
    endtask

    task automatic t_seed();
        write_seed(0, 8'hF0);
        cfg_sel = 0; #1; chk("R2 msb dropped", cfg_rdata, 8'h70);
        write_seed(1, 8'h10);
        cfg_sel = 1; #1; chk("R2 max seed", cfg_rdata, 8'h10);
        check_all("R2 extremes untouched");
    endtask

    task automatic t_track();
        step(1, 50, 0, 127);  check_all("R3 first sample");
        step(1, 80, 0, 127);  check_all("R4 new max");
        step(1, 20, 0, 127);  check_all("R3 new min");
        step(1, 40, 0, 127);  check_all("R5 inside sample");
    endtask

    task automatic t_fault();
        step(0, 0, 0, 60);    check_all("R6 equal limit no set");
        step(0, 0, 0, 59);    check_all("R6 over limit sets");
        step(0, 0, 0, 127);   check_all("R7 sticky high limit");
        step(1, 30, 0, 127);  check_all("R7 sticky with sample");
    endtask

    task automatic t_clear();
        step(0, 0, 1, 0);     check_all("R8 reload");
        step(0, 0, 0, 0);     check_all("R10 seeded quiet");
        step(0, 0, 0, 0);     check_all("R10 seeded quiet 2");
    endtask

    task automatic t_collide();
        step(1, 5, 0, 127);   check_all("R3 before collide");
        step(1, 5, 1, 127);   check_all("R9 clear wins");
        step(1, 30, 0, 0);    check_all("R9 next sample");
        step(0, 0, 0, 0);     check_all("R6 zero spread at zero limit");
        step(1, 90, 0, 0);    check_all("R4 after collide");
        step(0, 0, 0, 0);     check_all("R6 flag at zero limit");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        t_reset();
        t_seed();
        t_track();
        t_fault();
        t_clear();
        t_collide();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule